// File: doc/BRIEF.md
# Hex Record Stream Loader

The loader accepts a stream of ASCII characters, one per valid/ready handshake, that carries hexadecimal object records. Each record starts with a colon and holds, in this order: a byte count (two hex digits), a 16-bit load address (four hex digits), a record type (two hex digits), the payload bytes and a checksum byte. For each payload byte of a data record the loader issues a one-cycle write to a byte-wide memory port. Extended segment records change a 16-bit segment value, and that value, shifted left by four bits, is added to every later write address.

Characters outside a record, such as line ends or stray text, are dropped while the loader waits for the next colon. The loader keeps sticky flags for checksum mismatches, malformed characters and illegal record types. It stops once it sees an end-of-file record or a record whose count and address are both zero. It is placed between a character source and a memory that is being preloaded, and the memory side sees only plain byte writes.

Top module: `hexrec_loader`

## Requirements
- R1: After a synchronous reset, `done`, `wr_en` and all three error flags are 0 and `in_ready` is 1.
- R2: A character accepted while the loader waits for a record start is ignored unless it is a colon (0x3A). Such characters, including CR and LF, cause no write and set no flag.
- R3: Inside a record, the characters '0'-'9', 'A'-'F' and 'a'-'f' decode to 0-15 and each pair forms a byte, first digit in the upper nibble. The fields are count, address (upper digit first), type, payload and checksum.
- R4: For type 0x00, payload byte k (k counting from 0) is written once, with `wr_en` high for exactly one cycle. The cycle follows the acceptance of that byte's second digit, and the address is segment*16 + load address + k, cut to `ADDR_W` bits.
- R5: For type 0x02, the payload bytes are shifted into the 16-bit segment, first byte as the upper half. The new segment applies to every later data record. The segment starts at 0.
- R6: When the 8-bit sum of all bytes from the count through the checksum is not 0, `cksum_err` is set and stays set. Writes already issued from that record remain.
- R7: When the upper type digit is not '0', `type_err` is set and stays set, and the record issues no writes.
- R8: A non-hex character inside a record sets the sticky `fmt_err` and returns the loader to waiting for a colon. A colon inside a record also sets `fmt_err` and starts a new record at once.
- R9: When the checksum byte of a type 0x01 record is accepted, `done` goes to 1 and stays there, `in_ready` drops to 0 and no more writes occur.
- R10: A record whose count and address are both zero also ends loading as in R9, whatever its type.
- R11: Reset also clears the segment and the flags, so a data record after reset writes at its plain load address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Character present on `in_char` |
| in_ready | output | 1 | Loader takes a character this cycle (low once done) |
| in_char | input | 8 | ASCII character |
| wr_en | output | 1 | One-cycle write strobe |
| wr_addr | output | ADDR_W | Write byte address |
| wr_data | output | 8 | Write byte |
| done | output | 1 | Loading finished |
| cksum_err | output | 1 | Sticky checksum mismatch |
| fmt_err | output | 1 | Sticky malformed character |
| type_err | output | 1 | Sticky illegal record type |

## Verification
The end of loading and the checksum verdict are both decided on the same character: the second digit of the checksum byte. An end-of-file record with a deliberately wrong checksum therefore has to raise `done` and `cksum_err` on one clock edge. The bench sends such a record with its final character held back. It confirms both flags are low before that character and both are high in the cycle right after it is accepted. It also confirms that `in_ready` has fallen and that later characters produce no writes.

// File: rtl/hexrec_pkg.sv
package hexrec_pkg;

  typedef enum logic [2:0] {
    PH_HUNT,
    PH_COUNT,
    PH_ADDR,
    PH_TYPE,
    PH_DATA,
    PH_CHECK,
    PH_DONE
  } phase_t;

  localparam logic [7:0] CH_COLON = 8'h3A;
  localparam logic [7:0] TY_DATA  = 8'h00;
  localparam logic [7:0] TY_EOF   = 8'h01;
  localparam logic [7:0] TY_SEG   = 8'h02;

  // returns {is_hex, value}
  function automatic logic [4:0] ascii_nibble(input logic [7:0] c);
    logic [7:0] t;
    t = 8'h00;
    if (c >= 8'h30 && c <= 8'h39) begin
      t = c - 8'h30;
      return {1'b1, t[3:0]};
    end else if (c >= 8'h41 && c <= 8'h46) begin
      t = c - 8'h37;
      return {1'b1, t[3:0]};
    end else if (c >= 8'h61 && c <= 8'h66) begin
      t = c - 8'h57;
      return {1'b1, t[3:0]};
    end
    return {1'b0, t[3:0]};
  endfunction

  // segment*16 + load address + byte index, full width
  function automatic logic [31:0] target_addr(input logic [15:0] seg,
                                              input logic [15:0] base,
                                              input logic [7:0]  idx);
    return ({16'h0000, seg} << 4) + {16'h0000, base} + {24'h000000, idx};
  endfunction

endpackage

// File: rtl/hexrec_digit.sv
module hexrec_digit
  import hexrec_pkg::*;
(
  input  logic [7:0] ch,
  output logic [3:0] nib,
  output logic       is_hex,
  output logic       is_colon
);
  logic [4:0] dec;

  always_comb begin
    dec      = ascii_nibble(ch);
    nib      = dec[3:0];
    is_hex   = dec[4];
    is_colon = (ch == CH_COLON);
  end
endmodule

// File: rtl/hexrec_cksum.sv
module hexrec_cksum (
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       add,
  input  logic [7:0] byte_in,
  output logic       sum_ok
);
  logic [7:0] sum_q;
  logic [7:0] total;

  always_comb begin
    total  = sum_q + byte_in;
    sum_ok = (total == 8'h00);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) sum_q <= 8'h00;
    else if (add)   sum_q <= total;
  end
endmodule

// File: rtl/hexrec_loader.sv
module hexrec_loader
  import hexrec_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_char,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              done,
  output logic              cksum_err,
  output logic              fmt_err,
  output logic              type_err
);
  localparam int POS_W = 2;
  localparam logic [POS_W-1:0] ADDR_LAST = POS_W'(3);

  phase_t ph;
  logic [POS_W-1:0] pos;
  logic [3:0]  hi4;
  logic [7:0]  cnt, typ, idx;
  logic [15:0] adr, seg;

  logic [3:0] nib;
  logic is_hex, is_colon;
  logic sum_ok;

  hexrec_digit u_digit (
    .ch(in_char), .nib(nib), .is_hex(is_hex), .is_colon(is_colon)
  );

  // named events
  logic acc, in_rec, second, byte_done, hunt_skip, wr_fire, rec_close, end_rec;
  logic [7:0]  cur_byte;
  logic [7:0]  idx_nx;
  logic [31:0] tgt;

  always_comb begin
    in_ready  = (ph != PH_DONE);
    done      = (ph == PH_DONE);
    acc       = in_valid && in_ready;
    in_rec    = (ph != PH_HUNT) && (ph != PH_DONE);
    second    = pos[0];
    cur_byte  = {hi4, nib};
    byte_done = acc && in_rec && is_hex && second;
    hunt_skip = acc && (ph == PH_HUNT) && !is_colon;
    wr_fire   = byte_done && (ph == PH_DATA) && (typ == TY_DATA);
    rec_close = byte_done && (ph == PH_CHECK);
    end_rec   = (typ == TY_EOF) || (cnt == 8'h00 && adr == 16'h0000);
    idx_nx    = idx + 8'd1;
    tgt       = target_addr(seg, adr, idx);
  end

  hexrec_cksum u_cksum (
    .clk(clk), .rst(rst),
    .clr(acc && is_colon),
    .add(byte_done),
    .byte_in(cur_byte),
    .sum_ok(sum_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_HUNT;
      pos       <= '0;
      hi4       <= 4'h0;
      cnt       <= 8'h00;
      typ       <= 8'h00;
      idx       <= 8'h00;
      adr       <= 16'h0000;
      seg       <= 16'h0000;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= 8'h00;
      cksum_err <= 1'b0;
      fmt_err   <= 1'b0;
      type_err  <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (acc) begin
        if (ph == PH_HUNT) begin
          if (is_colon) begin
            ph  <= PH_COUNT;
            pos <= '0;
          end
        end else if (is_colon) begin
          fmt_err <= 1'b1;
          ph      <= PH_COUNT;
          pos     <= '0;
        end else if (!is_hex) begin
          fmt_err <= 1'b1;
          ph      <= PH_HUNT;
        end else begin
          hi4 <= nib;
          pos <= pos + 1'b1;
          case (ph)
            PH_COUNT: if (second) begin
              cnt <= cur_byte;
              ph  <= PH_ADDR;
              pos <= '0;
            end
            PH_ADDR: begin
              adr <= {adr[11:0], nib};
              if (pos == ADDR_LAST) begin
                ph  <= PH_TYPE;
                pos <= '0;
              end
            end
            PH_TYPE: if (second) begin
              typ <= cur_byte;
              if (hi4 != 4'h0) type_err <= 1'b1;
              idx <= 8'h00;
              pos <= '0;
              ph  <= (cnt == 8'h00) ? PH_CHECK : PH_DATA;
            end
            PH_DATA: if (second) begin
              pos <= '0;
              if (typ == TY_DATA) begin
                wr_en   <= 1'b1;
                wr_addr <= tgt[ADDR_W-1:0];
                wr_data <= cur_byte;
              end
              if (typ == TY_SEG) seg <= {seg[7:0], cur_byte};
              idx <= idx_nx;
              if (idx_nx == cnt) ph <= PH_CHECK;
            end
            PH_CHECK: if (second) begin
              pos <= '0;
              if (!sum_ok) cksum_err <= 1'b1;
              ph <= end_rec ? PH_DONE : PH_HUNT;
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R1 R11
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!done && !wr_en && !cksum_err && !fmt_err && !type_err));

  // R2
  hunt_skip_chk: assert property (@(posedge clk) disable iff (rst)
    hunt_skip |=> (!wr_en && ph == PH_HUNT));

  // R4
  wr_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  // R4
  wr_source_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(wr_fire));

  // R6
  cks_hold_chk: assert property (@(posedge clk) disable iff (rst)
    cksum_err |=> cksum_err);

  // R7
  type_hold_chk: assert property (@(posedge clk) disable iff (rst)
    type_err |=> type_err);

  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_err |=> fmt_err);

  // R9
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (done && !in_ready));

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_en);

  // R10
  zero_end_chk: assert property (@(posedge clk) disable iff (rst)
    (rec_close && cnt == 8'h00 && adr == 16'h0000) |=> done);

endmodule

// File: tb/sim_hexrec_loader.sv
module sim_hexrec_loader;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [7:0] in_char = 8'h00;
  logic in_ready, wr_en, done, cksum_err, fmt_err, type_err;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  hexrec_loader #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .cksum_err(cksum_err), .fmt_err(fmt_err), .type_err(type_err)
  );

  // write log
  logic [AW-1:0] log_a [64];
  logic [7:0]    log_d [64];
  int log_n = 0;
  always @(negedge clk) begin
    if (wr_en && log_n < 64) begin
      log_a[log_n] = wr_addr;
      log_d[log_n] = wr_data;
      log_n = log_n + 1;
    end
  end

  // {count, load address, type, up to four payload bytes (first in top)}
  localparam logic [63:0] RECS [7] = '{
    {8'd3, 16'h0100, 8'h00, 32'h11223300},
    {8'd2, 16'h0000, 8'h02, 32'h10000000},
    {8'd2, 16'h0010, 8'h00, 32'hABCD0000},
    {8'd1, 16'hFFFF, 8'h00, 32'h5E000000},
    {8'd2, 16'h0000, 8'h02, 32'h00000000},
    {8'd0, 16'h0050, 8'h00, 32'h00000000},
    {8'd1, 16'h0200, 8'h00, 32'h7F000000}
  };
  localparam logic [27:0] EXPW [7] = '{
    {20'h00100, 8'h11}, {20'h00101, 8'h22}, {20'h00102, 8'h33},
    {20'h10010, 8'hAB}, {20'h10011, 8'hCD},
    {20'h1FFFF, 8'h5E},
    {20'h00200, 8'h7F}
  };

  task automatic chk(input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // builds a record with its checksum; bad=1 corrupts the checksum
  function automatic string mk_rec(input int n, input int a, input int ty,
                                   input logic [31:0] pl, input bit bad);
    string s;
    int acc;
    int ck;
    acc = n + (a >> 8) + (a & 255) + ty;
    s = $sformatf(":%02X%04X%02X", n, a, ty);
    for (int k = 0; k < n; k++) begin
      int b;
      b = int'(pl[31-8*k -: 8]);
      acc += b;
      s = {s, $sformatf("%02X", b)};
    end
    ck = (256 - (acc % 256)) % 256;
    if (bad) ck = ck ^ 1;
    s = {s, $sformatf("%02X", ck)};
    return s;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic send_ch(input logic [7:0] c);
    in_valid = 1'b1;
    in_char  = c;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send_ch(s[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    int wexp;
    string s;

    do_reset();
    // R1 reset state
    chk("R1", "done", 32'(done), 0);
    chk("R1", "wr_en", 32'(wr_en), 0);
    chk("R1", "flags", {29'd0, cksum_err, fmt_err, type_err}, 0);
    chk("R1", "in_ready", 32'(in_ready), 1);

    // R2 junk outside records
    base = log_n;
    send_str("hello 7F\r\n");
    chk("R2", "writes after junk", 32'(log_n - base), 0);
    chk("R2", "flags after junk", {29'd0, cksum_err, fmt_err, type_err}, 0);

    // table walk: R3 R4 R5
    base = log_n;
    wexp = 0;
    foreach (RECS[i]) begin
      s = mk_rec(int'(RECS[i][63:56]), int'(RECS[i][55:40]),
                 int'(RECS[i][39:32]), RECS[i][31:0], 1'b0);
      send_str(s);
      send_str("\r\n");
      if (RECS[i][39:32] == 8'h00) wexp += int'(RECS[i][63:56]);
      chk("R4", $sformatf("write count after record %0d", i), 32'(log_n - base), 32'(wexp));
    end
    foreach (EXPW[j]) begin
      chk("R4", $sformatf("addr of write %0d", j), 32'(log_a[base+j]), 32'(EXPW[j][27:8]));
      chk("R3", $sformatf("data of write %0d", j), 32'(log_d[base+j]), 32'(EXPW[j][7:0]));
    end
    chk("R6", "no checksum error on good records", 32'(cksum_err), 0);
    chk("R5", "segment records left done low", 32'(done), 0);

    // R3 lowercase digits
    base = log_n;
    s = mk_rec(1, 'h0300, 0, 32'hBE000000, 1'b0);
    send_str(s.tolower());
    chk("R3", "lowercase write count", 32'(log_n - base), 1);
    chk("R3", "lowercase addr", 32'(log_a[base]), 32'h00300);
    chk("R3", "lowercase data", 32'(log_d[base]), 32'hBE);

    // R6 bad checksum keeps its write
    base = log_n;
    send_str(mk_rec(1, 'h0400, 0, 32'h44000000, 1'b1));
    chk("R6", "cksum_err set", 32'(cksum_err), 1);
    chk("R6", "bad record still wrote", 32'(log_n - base), 1);
    chk("R6", "bad record data", 32'(log_d[base]), 32'h44);
    send_str(mk_rec(1, 'h0401, 0, 32'h45000000, 1'b0));
    chk("R6", "cksum_err sticky", 32'(cksum_err), 1);

    // R7 illegal type
    do_reset();
    base = log_n;
    send_str(mk_rec(1, 'h0500, 'h10, 32'h55000000, 1'b0));
    chk("R7", "type_err set", 32'(type_err), 1);
    chk("R7", "illegal record wrote nothing", 32'(log_n - base), 0);

    // R8 non-hex inside record, then resync
    do_reset();
    base = log_n;
    send_str(":0105G0");
    chk("R8", "fmt_err on non-hex", 32'(fmt_err), 1);
    send_str(mk_rec(1, 'h0600, 0, 32'h66000000, 1'b0));
    chk("R8", "resync write count", 32'(log_n - base), 1);
    chk("R8", "resync addr", 32'(log_a[base]), 32'h00600);

    // R8 colon inside record restarts
    do_reset();
    base = log_n;
    send_str(":0107");
    chk("R8", "fmt_err clear before colon", 32'(fmt_err), 0);
    send_str(mk_rec(1, 'h0700, 0, 32'h77000000, 1'b0));
    chk("R8", "fmt_err on inner colon", 32'(fmt_err), 1);
    chk("R8", "restarted record wrote", 32'(log_n - base), 1);
    chk("R8", "restarted data", 32'(log_d[base]), 32'h77);

    // R10 zero count and zero address with type 05 ends loading
    do_reset();
    send_str(mk_rec(2, 0, 2, 32'h20000000, 1'b0));
    send_str(mk_rec(0, 0, 5, 32'h0, 1'b0));
    chk("R10", "done after zero record", 32'(done), 1);
    chk("R10", "in_ready low", 32'(in_ready), 0);
    chk("R10", "no checksum error", 32'(cksum_err), 0);
    base = log_n;
    in_valid = 1'b1;
    in_char  = 8'h3A;
    repeat (3) @(negedge clk);
    in_char = 8'h30;
    repeat (3) @(negedge clk);
    in_valid = 1'b0;
    chk("R9", "no writes while done", 32'(log_n - base), 0);
    chk("R9", "done holds", 32'(done), 1);

    // R11 reset clears segment and done
    do_reset();
    chk("R11", "done cleared", 32'(done), 0);
    chk("R11", "in_ready back", 32'(in_ready), 1);
    base = log_n;
    send_str(mk_rec(1, 'h0020, 0, 32'h99000000, 1'b0));
    chk("R11", "addr uses cleared segment", 32'(log_a[base]), 32'h00020);

    // R9 with R6: end-of-file with bad checksum, both on one edge
    s = mk_rec(0, 'h1234, 1, 32'h0, 1'b1);
    send_str(s.substr(0, s.len() - 2));
    chk("R9", "done low before last char", 32'(done), 0);
    chk("R6", "cksum_err low before last char", 32'(cksum_err), 0);
    send_ch(s[s.len() - 1]);
    chk("R9", "done on last char", 32'(done), 1);
    chk("R6", "cksum_err on same edge", 32'(cksum_err), 1);
    chk("R9", "in_ready dropped", 32'(in_ready), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule